// File: doc/BRIEF.md
# Chained-Descriptor Receive DMA Writer

This block takes received Ethernet frames as a byte stream from a MAC and places them in memory. Each buffer is described by a descriptor in memory: four 32-bit words holding a status word, a control word with the buffer size, the buffer address and the address of the next descriptor. The engine reads the current descriptor through a single-word memory master port and checks that it owns it. It then packs frame bytes into 32-bit words inside the buffer. When a buffer is full or the frame ends, it writes the status word back with ownership returned to software, and moves on to the next descriptor.

A frame larger than one buffer continues in the following descriptors. Frames that arrive while the current descriptor still belongs to software are thrown away and counted in a saturating missed-frame counter. Software uses a small register port to program the address of the first descriptor, to start and stop reception, and to read the counter, which clears when it is read.

Top module: `rxdma_writer`

## Requirements
- R1: After reset every register reads zero, `rx_ready` is low, and no memory request is made until reception is started and a byte is offered.
- R2: At the start of a frame and at each spill into a new buffer, the engine reads the four descriptor words in the order status, control, buffer pointer, next pointer. Status bit 31 set means the engine owns the descriptor. No frame byte is accepted while a memory access is outstanding.
- R3: Frame bytes are stored in little-endian order (the first byte in bits 7:0) in consecutive 32-bit words starting at the buffer pointer. A final partial word is padded with zeros. The buffer size in control bits 10:0 is a byte count and must be a multiple of 4.
- R4: A frame that fits in one buffer gets one status write-back with bit 31 clear, bit 9 (first) and bit 8 (last) set, and the byte count including the 4 CRC bytes in bits 29:16.
- R5: A frame that spans several buffers marks only its first descriptor with bit 9 and only its last with bit 8. Only the last descriptor carries the length, the multicast flag in bit 10 and the error flag in bit 15, both sampled with the last byte. Middle descriptors write back zero.
- R6: After a write-back, the next descriptor comes from the next-pointer word when control bit 24 is set, and otherwise from the current descriptor address plus 16.
- R7: If the descriptor is not owned when a frame starts, the whole frame is accepted and discarded. Nothing is written to memory, the descriptor pointer is unchanged, and the missed counter increments.
- R8: If the next descriptor is not owned when a frame spills, the rest of the frame is discarded and the missed counter increments. Earlier buffers of that frame keep their write-backs.
- R9: The missed counter saturates at all ones.
- R10: The missed counter reads at offset 0x20 and clears on that read. An increment in the same cycle leaves it at 1.
- R11: Control offset 0x18 bit 1 starts reception. Clearing it lets a frame in progress complete with its write-back. After that no byte is accepted and no descriptor is fetched.
- R12: Offset 0x0C holds the ring base and reads back. Writing it while no frame is in progress sets the descriptor the next frame will use.
- R13: A memory request keeps its address, direction and write data stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the missed counter at 0x20) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| mem_req | output | 1 | Memory access request, held until `mem_ack` |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle acknowledge; read data valid with it |
| mem_rdata | input | 32 | Read data |
| rx_valid | input | 1 | A received byte is offered |
| rx_ready | output | 1 | The offered byte is taken this cycle |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| rx_mcast | input | 1 | Frame is multicast, valid with the last byte |
| rx_crc_err | input | 1 | Frame failed its CRC, valid with the last byte |

## Verification
Frames are sent with lengths of 10, 16, 40, 20, 4, 12 and 6 bytes against 16-byte buffers. This separates a padded partial word, an exact buffer fill, a three-way spill, and a spill that runs into a descriptor still held by software. Ownership is withheld both at frame start and in mid-frame, so a whole-frame drop can be told apart from a tail drop, and enough drops follow to saturate a 3-bit counter. One descriptor clears its chain bit while pointing elsewhere, to show whether the sequential address or the pointer is followed. Reception is stopped in the middle of a frame, and the ring base is moved, to confirm which descriptor the next frame lands in.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    localparam int BSZ_W = 11;          // buffer size field width (bytes)
    localparam int LEN_W = 14;          // frame length field width

    // register offsets
    localparam logic [7:0] OFS_BASE = 8'h0C;
    localparam logic [7:0] OFS_CTRL = 8'h18;
    localparam logic [7:0] OFS_MISS = 8'h20;
    localparam int CTRL_START = 1;

    // descriptor bit positions
    localparam int ST_OWN    = 31;
    localparam int ST_ERR    = 15;
    localparam int ST_MC     = 10;
    localparam int ST_FIRST  = 9;
    localparam int ST_LAST   = 8;
    localparam int ST_LEN_LO = 16;
    localparam int CTL_CHAIN = 24;

    localparam logic [31:0] DESC_STRIDE = 32'd16;

    typedef enum logic [3:0] {
        E_IDLE,
        E_RD_ST,
        E_RD_CTL,
        E_RD_BUF,
        E_RD_NXT,
        E_DATA,
        E_WR_WORD,
        E_WB,
        E_DROP
    } eng_st_t;

    typedef struct packed {
        logic             chain;
        logic [BSZ_W-1:0] bsize;
        logic [31:0]      buf_ptr;
        logic [31:0]      nxt_ptr;
    } desc_t;

    function automatic logic [31:0] wb_word(input logic [LEN_W-1:0] len,
                                            input logic first,
                                            input logic last,
                                            input logic mc,
                                            input logic err);
        logic [31:0] w;
        w = '0;
        w[ST_LEN_LO +: LEN_W] = len;
        w[ST_FIRST] = first;
        w[ST_LAST]  = last;
        w[ST_MC]    = mc;
        w[ST_ERR]   = err;
        w[ST_OWN]   = 1'b0;
        return w;
    endfunction

endpackage

// File: rtl/rxd_regs.sv
module rxd_regs
    import rxd_pkg::*;
#(
    parameter int MISS_W = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        miss_inc,
    output logic        start,
    output logic        base_ld,
    output logic [31:0] base_val
);

    logic [31:0]       base_q;
    logic              start_q;
    logic [MISS_W-1:0] miss_q;
    logic              rd_clr;

    assign rd_clr   = reg_rd && (reg_addr == OFS_MISS);
    assign base_ld  = reg_wr && (reg_addr == OFS_BASE);
    assign base_val = reg_wdata;
    assign start    = start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            start_q <= 1'b0;
            miss_q  <= '0;
        end else begin
            if (base_ld)
                base_q <= reg_wdata;
            if (reg_wr && (reg_addr == OFS_CTRL))
                start_q <= reg_wdata[CTRL_START];
            if (rd_clr)
                miss_q <= miss_inc ? MISS_W'(1) : '0;
            else if (miss_inc && (miss_q != {MISS_W{1'b1}}))
                miss_q <= miss_q + 1'b1;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_BASE: reg_rdata = base_q;
            OFS_CTRL: reg_rdata[CTRL_START] = start_q;
            OFS_MISS: reg_rdata[MISS_W-1:0] = miss_q;
            default:  reg_rdata = '0;
        endcase
    end

    // R9
    miss_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (miss_q == {MISS_W{1'b1}} && !rd_clr) |=> (miss_q == {MISS_W{1'b1}}));

    // R10
    miss_clr_chk: assert property (@(posedge clk) disable iff (rst)
        rd_clr |=> (miss_q <= MISS_W'(1)));

endmodule

// File: rtl/rxd_packer.sv
module rxd_packer (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        push,
    input  logic [7:0]  din,
    output logic [31:0] word,
    output logic [2:0]  nbytes
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            word   <= '0;
            nbytes <= '0;
        end else if (push) begin
            word[8*nbytes[1:0] +: 8] <= din;
            nbytes <= nbytes + 1'b1;
        end
    end

    // R3
    pack_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (nbytes == 3'd4) |-> !push);

endmodule

// File: rtl/rxd_engine.sv
module rxd_engine
    import rxd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        base_ld,
    input  logic [31:0] base_val,
    output logic        miss_inc,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    input  logic        rx_valid,
    output logic        rx_ready,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    input  logic        rx_mcast,
    input  logic        rx_crc_err
);

    eng_st_t          st;
    desc_t            dsc;
    logic [31:0]      cur;
    logic [BSZ_W-1:0] bcnt;
    logic [BSZ_W-1:0] bcnt_nx;
    logic [BSZ_W-1:0] bcnt_m1;
    logic [LEN_W-1:0] flen;
    logic             first_q, done_q, mc_q, err_q;
    logic [31:0]      pk_word;
    logic [2:0]       pk_n;
    logic             pk_push, pk_clr;

    assign bcnt_nx  = bcnt + 1'b1;
    assign bcnt_m1  = bcnt - 1'b1;
    assign pk_push  = (st == E_DATA) && rx_valid;
    assign pk_clr   = (st == E_WR_WORD) && mem_ack;
    assign miss_inc = (st == E_DROP) && rx_valid && rx_last;
    assign rx_ready = (st == E_DATA) || (st == E_DROP);

    rxd_packer u_pack (
        .clk    (clk),
        .rst    (rst),
        .clr    (pk_clr),
        .push   (pk_push),
        .din    (rx_data),
        .word   (pk_word),
        .nbytes (pk_n)
    );

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (st)
            E_RD_ST:  begin mem_req = 1'b1; mem_addr = cur; end
            E_RD_CTL: begin mem_req = 1'b1; mem_addr = cur + 32'd4; end
            E_RD_BUF: begin mem_req = 1'b1; mem_addr = cur + 32'd8; end
            E_RD_NXT: begin mem_req = 1'b1; mem_addr = cur + 32'd12; end
            E_WR_WORD: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dsc.buf_ptr + {{(32-BSZ_W){1'b0}}, bcnt_m1[BSZ_W-1:2], 2'b00};
                mem_wdata = pk_word;
            end
            E_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur;
                mem_wdata = wb_word(done_q ? flen : '0, first_q, done_q,
                                    done_q & mc_q, done_q & err_q);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= E_IDLE;
            dsc     <= '0;
            cur     <= '0;
            bcnt    <= '0;
            flen    <= '0;
            first_q <= 1'b0;
            done_q  <= 1'b0;
            mc_q    <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            case (st)
                E_IDLE: begin
                    if (start && rx_valid) begin
                        st      <= E_RD_ST;
                        first_q <= 1'b1;
                        done_q  <= 1'b0;
                        mc_q    <= 1'b0;
                        err_q   <= 1'b0;
                        flen    <= '0;
                    end
                    if (base_ld)
                        cur <= base_val;
                end
                E_RD_ST: if (mem_ack)
                    st <= mem_rdata[ST_OWN] ? E_RD_CTL : E_DROP;
                E_RD_CTL: if (mem_ack) begin
                    dsc.bsize <= mem_rdata[BSZ_W-1:0];
                    dsc.chain <= mem_rdata[CTL_CHAIN];
                    st        <= E_RD_BUF;
                end
                E_RD_BUF: if (mem_ack) begin
                    dsc.buf_ptr <= mem_rdata;
                    st          <= E_RD_NXT;
                end
                E_RD_NXT: if (mem_ack) begin
                    dsc.nxt_ptr <= mem_rdata;
                    bcnt        <= '0;
                    st          <= E_DATA;
                end
                E_DATA: if (rx_valid) begin
                    bcnt <= bcnt_nx;
                    flen <= flen + 1'b1;
                    if (rx_last) begin
                        done_q <= 1'b1;
                        mc_q   <= rx_mcast;
                        err_q  <= rx_crc_err;
                    end
                    if (pk_n == 3'd3 || rx_last || bcnt_nx == dsc.bsize)
                        st <= E_WR_WORD;
                end
                E_WR_WORD: if (mem_ack)
                    st <= (done_q || bcnt == dsc.bsize) ? E_WB : E_DATA;
                E_WB: if (mem_ack) begin
                    first_q <= 1'b0;
                    cur     <= dsc.chain ? dsc.nxt_ptr : cur + DESC_STRIDE;
                    st      <= done_q ? E_IDLE : E_RD_ST;
                end
                E_DROP: if (rx_valid && rx_last)
                    st <= E_IDLE;
                default: st <= E_IDLE;
            endcase
        end
    end

    // R13
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    // R2
    no_accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        rx_ready |-> !mem_req);

    // R4
    wb_release_chk: assert property (@(posedge clk) disable iff (rst)
        (st == E_WB && mem_req) |-> !mem_wdata[ST_OWN]);

    // R5
    mid_len_chk: assert property (@(posedge clk) disable iff (rst)
        (st == E_WB && !done_q) |-> (mem_wdata[ST_LEN_LO +: LEN_W] == '0 && !mem_wdata[ST_LAST]));

endmodule

// File: rtl/rxdma_writer.sv
module rxdma_writer
    import rxd_pkg::*;
#(
    parameter int MISS_W = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    input  logic        rx_valid,
    output logic        rx_ready,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    input  logic        rx_mcast,
    input  logic        rx_crc_err
);

    logic        start;
    logic        base_ld;
    logic [31:0] base_val;
    logic        miss_inc;

    rxd_regs #(.MISS_W(MISS_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .miss_inc  (miss_inc),
        .start     (start),
        .base_ld   (base_ld),
        .base_val  (base_val)
    );

    rxd_engine u_eng (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .base_ld    (base_ld),
        .base_val   (base_val),
        .miss_inc   (miss_inc),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .rx_valid   (rx_valid),
        .rx_ready   (rx_ready),
        .rx_data    (rx_data),
        .rx_last    (rx_last),
        .rx_mcast   (rx_mcast),
        .rx_crc_err (rx_crc_err)
    );

endmodule

// File: tb/tb_rxdma_writer.sv
`timescale 1ns/1ps
module tb_rxdma_writer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        rx_valid = 1'b0, rx_ready, rx_last = 1'b0, rx_mcast = 1'b0, rx_crc_err = 1'b0;
    logic [7:0]  rx_data = '0;

    int n_chk = 0;
    int n_bad = 0;
    int viol  = 0;

    logic [31:0] mem [0:1023];
    logic [31:0] q_addr[$];
    logic [31:0] q_val[$];

    always #2.5 clk = ~clk;

    rxdma_writer #(.MISS_W(3)) dut (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .rx_last(rx_last), .rx_mcast(rx_mcast), .rx_crc_err(rx_crc_err)
    );

    // memory model with monitor of descriptor write-backs (scoreboard)
    logic        ack_q = 1'b0;
    logic [31:0] rd_q = '0;
    logic        p_req = 1'b0, p_ack = 1'b0;
    logic [31:0] p_addr = '0;
    assign mem_ack   = ack_q;
    assign mem_rdata = rd_q;

    always @(posedge clk) begin
        if (rst) begin
            ack_q <= 1'b0;
            p_req <= 1'b0;
        end else begin
            // R13 request must persist with the same address until acknowledged
            if (p_req && !p_ack && (!mem_req || mem_addr != p_addr))
                viol = viol + 1;
            p_req  <= mem_req;
            p_ack  <= ack_q;
            p_addr <= mem_addr;
            if (mem_req && !ack_q) begin
                ack_q <= 1'b1;
                if (mem_we) begin
                    mem[mem_addr[11:2]] <= mem_wdata;
                    if (mem_addr < 32'h100 && mem_addr[3:0] == 4'h0) begin
                        n_chk = n_chk + 1;
                        if (q_addr.size() == 0) begin
                            n_bad = n_bad + 1;
                            $display("FAIL R4 unexpected write-back addr=%h val=%h expected none",
                                     mem_addr, mem_wdata);
                        end else begin
                            logic [31:0] ea, ev;
                            ea = q_addr.pop_front();
                            ev = q_val.pop_front();
                            if (ea != mem_addr || ev != mem_wdata) begin
                                n_bad = n_bad + 1;
                                $display("FAIL R4/R5/R6 write-back got addr=%h val=%h expected addr=%h val=%h",
                                         mem_addr, mem_wdata, ea, ev);
                            end
                        end
                    end
                end else begin
                    rd_q <= mem[mem_addr[11:2]];
                end
            end else begin
                ack_q <= 1'b0;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (got !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic push_exp(input logic [31:0] a, input logic [31:0] v);
        q_addr.push_back(a);
        q_val.push_back(v);
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic set_desc(input logic [31:0] a, input logic own, input logic chain,
                            input logic [31:0] bufp, input logic [31:0] nxt);
        mem[a[11:2]]        <= own ? 32'h8000_0000 : 32'h0;
        mem[a[11:2] + 10'd1] <= (chain ? 32'h0100_0000 : 32'h0) | 32'd16;
        mem[a[11:2] + 10'd2] <= bufp;
        mem[a[11:2] + 10'd3] <= nxt;
        @(negedge clk);
    endtask

    task automatic give(input logic [31:0] a, input logic own);
        mem[a[11:2]] <= own ? 32'h8000_0000 : 32'h0;
        @(negedge clk);
    endtask

    task automatic send_frame(input int len, input logic [7:0] seed, input logic mc,
                              input logic err, input int stop_at);
        @(negedge clk);
        for (int i = 0; i < len; i++) begin
            if (i == stop_at) reg_write(8'h18, 32'h0);
            rx_data = seed + 8'(i); rx_last = (i == len - 1);
            rx_mcast = mc; rx_crc_err = err; rx_valid = 1'b1;
            while (!rx_ready) @(negedge clk);
            @(negedge clk);
            rx_valid = 1'b0; rx_last = 1'b0;
        end
    endtask

    task automatic wait_done();
        for (int k = 0; k < 2000 && q_addr.size() != 0; k++) @(negedge clk);
        repeat (6) @(negedge clk);
        check("R4 pending write-backs", 32'(q_addr.size()), 32'd0);
    endtask

    task automatic chk_buf(input string req, input logic [31:0] base, input int nb,
                           input logic [7:0] seed);
        for (int w = 0; w < (nb + 3) / 4; w++) begin
            logic [31:0] e;
            e = '0;
            for (int b = 0; b < 4; b++)
                if (w * 4 + b < nb) e[8*b +: 8] = seed + 8'(w * 4 + b);
            check(req, mem[base[11:2] + 10'(w)], e);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad = n_bad + 1;
        $display("FAIL watchdog expired got=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        for (int i = 0; i < 1024; i++) mem[i] = 32'hFFFF_FFFF;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        reg_read(8'h0C, rv); check("R1 base", rv, 0);
        reg_read(8'h18, rv); check("R1 ctrl", rv, 0);
        reg_read(8'h20, rv); check("R1 missed", rv, 0);
        check("R1 rx_ready/mem_req", {30'd0, rx_ready, mem_req}, 0);

        set_desc(32'h000, 1, 1, 32'h400, 32'h010);
        set_desc(32'h010, 1, 1, 32'h440, 32'h020);
        set_desc(32'h020, 1, 1, 32'h480, 32'h030);
        set_desc(32'h030, 1, 1, 32'h4C0, 32'h000);
        reg_write(8'h0C, 32'h0);
        reg_write(8'h18, 32'h2);
        reg_read(8'h18, rv); check("R11 ctrl readback", rv, 32'h2);

        // A: single buffer, partial last word (R2 R3 R4)
        push_exp(32'h000, 32'h000A_0300);
        send_frame(10, 8'h10, 0, 0, -1);
        wait_done();
        chk_buf("R3 padded buffer", 32'h400, 10, 8'h10);
        check("R3 pad bytes", mem[32'h408 >> 2], 32'h0000_1918);

        // B: spill over three buffers, multicast and error (R5 R2)
        push_exp(32'h010, 32'h0000_0200);
        push_exp(32'h020, 32'h0000_0000);
        push_exp(32'h030, 32'h0028_8500);
        send_frame(40, 8'h40, 1, 1, -1);
        wait_done();
        chk_buf("R5 first buffer", 32'h440, 16, 8'h40);
        chk_buf("R5 middle buffer", 32'h480, 16, 8'h50);
        chk_buf("R5 last buffer", 32'h4C0, 8, 8'h60);

        // C: exact fill, chained wrap to descriptor 0 (R6 R4)
        give(32'h000, 1);
        push_exp(32'h000, 32'h0010_0300);
        send_frame(16, 8'h80, 0, 0, -1);
        wait_done();
        chk_buf("R6 wrapped buffer", 32'h400, 16, 8'h80);

        // D: descriptor 1 held by software, whole frame dropped (R7 R10)
        send_frame(8, 8'hA0, 0, 0, -1);
        repeat (6) @(negedge clk);
        check("R7 status untouched", mem[32'h010 >> 2], 32'h0000_0200);
        check("R7 buffer untouched", mem[32'h440 >> 2], 32'h4342_4140);
        reg_read(8'h20, rv); check("R7 missed count", rv, 1);
        reg_read(8'h20, rv); check("R10 clear on read", rv, 0);

        // E: saturation (R9)
        for (int k = 0; k < 9; k++) send_frame(1, 8'h01, 0, 0, -1);
        repeat (6) @(negedge clk);
        reg_read(8'h20, rv); check("R9 saturated", rv, 7);
        reg_read(8'h20, rv); check("R10 cleared after saturation", rv, 0);

        // F: spill into a descriptor held by software (R8), pointer stayed at D1 (R7)
        give(32'h010, 1);
        give(32'h020, 0);
        push_exp(32'h010, 32'h0000_0200);
        send_frame(20, 8'hB0, 0, 0, -1);
        wait_done();
        chk_buf("R8 kept head buffer", 32'h440, 16, 8'hB0);
        reg_read(8'h20, rv); check("R8 missed count", rv, 1);

        // G: unchained descriptor goes to address+16 (R6)
        mem[32'h020 >> 2] <= 32'h8000_0000;
        mem[32'h024 >> 2] <= 32'd16;
        mem[32'h02C >> 2] <= 32'h100;
        @(negedge clk);
        push_exp(32'h020, 32'h0004_0300);
        send_frame(4, 8'hD0, 0, 0, -1);
        wait_done();
        give(32'h030, 1);
        push_exp(32'h030, 32'h0004_0300);
        send_frame(4, 8'hD8, 0, 0, -1);
        wait_done();
        chk_buf("R6 sequential buffer", 32'h4C0, 4, 8'hD8);

        // H: stop during a frame (R11)
        give(32'h000, 1);
        give(32'h010, 1);
        push_exp(32'h000, 32'h000C_0300);
        send_frame(12, 8'hE0, 0, 0, 3);
        wait_done();
        chk_buf("R11 completed frame", 32'h400, 12, 8'hE0);
        begin
            int busy = 0;
            rx_valid = 1'b1; rx_data = 8'h55; rx_last = 1'b1;
            for (int k = 0; k < 30; k++) begin
                @(negedge clk);
                if (rx_ready || mem_req) busy++;
            end
            rx_valid = 1'b0; rx_last = 1'b0;
            check("R11 stopped engine idle", 32'(busy), 0);
        end
        reg_read(8'h20, rv); check("R11 no miss while stopped", rv, 0);

        // I: move ring base (R12)
        set_desc(32'h040, 1, 1, 32'h500, 32'h000);
        reg_write(8'h0C, 32'h40);
        reg_read(8'h0C, rv); check("R12 base readback", rv, 32'h40);
        reg_write(8'h18, 32'h2);
        push_exp(32'h040, 32'h0006_0300);
        send_frame(6, 8'hC0, 0, 0, -1);
        wait_done();
        chk_buf("R12 frame at new base", 32'h500, 6, 8'hC0);

        check("R13 request stability violations", 32'(viol), 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule